// File: doc/BRIEF.md
# Link Training Retry and Stability Supervisor

This block watches a status word from a serial link controller and recovers the link on its own when training does not complete, so that no processor has to poll. It drives the controller's training-enable input. After training is enabled it waits a settling interval and then reads the status. If the link is down, it holds the enable low for a short pulse, raises it again and starts a new settling interval.

Once a read shows the link up, the block does not trust that single read. It reads the link again several more times, each read a fixed recheck interval after the previous one. It raises a stable flag only when every one of these reads passes. A failed recheck sends it back to the retry path with its count of good reads cleared. If the link drops after the flag is set, the flag clears and the block starts a new retry at once. A saturating counter reports how many failures have occurred since reset.

Top module: `lw_link_watchdog`

## Requirements
- R1: Out of reset, train_en is 1, link_stable is 0 and retry_count is 0.
- R2: The link counts as up only when every bit set in LINK_MASK (default 0x11, that is bits 0 and 4) is also set in link_status. The other status bits have no effect.
- R3: Each time training is enabled, the link is read once, on the last of SETTLE_CYC cycles. If that read shows the link down, train_en is 0 on the next cycle.
- R4: Each low pulse of train_en lasts exactly LOW_CYC cycles. A new settling interval follows it.
- R5: A passing settle read is followed by GOOD_NEEDED-1 further reads spaced RECHK_CYC cycles apart. If the link is up at every one of these reads, link_stable rises SETTLE_CYC+(GOOD_NEEDED-1)*RECHK_CYC cycles after train_en rose, and it stays 1 while the link stays up.
- R6: A recheck that reads the link down drops train_en on the next cycle, and it clears the good-read count. After such a failure, a full series of passing reads is again needed.
- R7: retry_count grows by 1 on each failure, whether a settle read, a recheck or a loss after the flag was set. It holds at 2^RETRY_W-1.
- R8: While link_stable is 1, a cycle in which the link reads down makes both link_stable and train_en 0 on the next cycle.
- R9: link_stable is never 1 while train_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_status | input | STATUS_W | Status word from the link controller |
| train_en | output | 1 | Training-enable drive to the controller |
| link_stable | output | 1 | Link has passed the full series of reads |
| retry_count | output | RETRY_W | Failure count, saturating |

## Verification
On every cycle, the checker confirms the following. Every fall of train_en follows a read that found the link down or a loss while stable. Every low pulse has exactly the configured width. The stable flag rises only on a passing read and never while training is disabled. The failure count only steps by one, and only as the enable falls. The directed scenarios cover what needs elapsed time or history. They measure the settling delay. They measure the exact cycle on which the flag rises after a series of rechecks, and they show that a failed recheck forces a full new series. They also show that status bits outside the mask are ignored and that the counter stops at its maximum.

// File: rtl/lw_pkg.sv
package lw_pkg;
  typedef enum logic [1:0] {
    ST_SETTLE  = 2'd0,
    ST_RECHECK = 2'd1,
    ST_LOW     = 2'd2,
    ST_STABLE  = 2'd3
  } lw_state_e;

  function automatic logic mask_all_set(input logic [63:0] word, input logic [63:0] mask);
    return (word & mask) == mask;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int stable_delay(input int settle, input int rechk, input int good);
    return settle + (good - 1) * rechk;
  endfunction
endpackage

// File: rtl/lw_interval_timer.sv
module lw_interval_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = (cnt_q == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart || expire) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lw_sat_counter.sv
module lw_sat_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  function automatic logic [W-1:0] sat_inc(input logic [W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= sat_inc(count);
  end
endmodule

// File: rtl/lw_link_watchdog.sv
module lw_link_watchdog
  import lw_pkg::*;
#(
  parameter int                STATUS_W    = 32,
  parameter logic [STATUS_W-1:0] LINK_MASK = 'h11,
  parameter int                SETTLE_CYC  = 150000,
  parameter int                RECHK_CYC   = 50000,
  parameter int                LOW_CYC     = 16,
  parameter int                GOOD_NEEDED = 4,
  parameter int                RETRY_W     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STATUS_W-1:0] link_status,
  output logic                train_en,
  output logic                link_stable,
  output logic [RETRY_W-1:0]  retry_count
);
  localparam int TMR_W  = $clog2(max3(SETTLE_CYC, RECHK_CYC, LOW_CYC) + 1);
  localparam int GOOD_W = $clog2(GOOD_NEEDED + 1);

  lw_state_e        state_q, state_d;
  logic [TMR_W-1:0] limit;
  logic             expire;
  logic             link_ok;
  logic [GOOD_W-1:0] good_q;

  // named internal events, used by the checker
  logic sample_evt;
  logic pass_evt;
  logic fail_evt;
  logic last_good;

  assign link_ok = mask_all_set(64'(link_status), 64'(LINK_MASK));

  always_comb begin
    unique case (state_q)
      ST_LOW:     limit = TMR_W'(LOW_CYC);
      ST_SETTLE:  limit = TMR_W'(SETTLE_CYC);
      ST_RECHECK: limit = TMR_W'(RECHK_CYC);
      default:    limit = TMR_W'(1);
    endcase
  end

  assign sample_evt = expire && (state_q == ST_SETTLE || state_q == ST_RECHECK);
  assign pass_evt   = sample_evt && link_ok;
  assign fail_evt   = (sample_evt && !link_ok) || (state_q == ST_STABLE && !link_ok);
  assign last_good  = pass_evt && (good_q == GOOD_W'(GOOD_NEEDED - 1));

  always_comb begin
    state_d = state_q;
    if (state_q == ST_LOW) begin
      if (expire) state_d = ST_SETTLE;
    end else if (fail_evt) begin
      state_d = ST_LOW;
    end else if (last_good) begin
      state_d = ST_STABLE;
    end else if (pass_evt) begin
      state_d = ST_RECHECK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_SETTLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          good_q <= '0;
    else if (fail_evt || state_q == ST_LOW) good_q <= '0;
    else if (pass_evt && !last_good)     good_q <= good_q + 1'b1;
  end

  lw_interval_timer #(.CNT_W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_d != state_q),
    .limit   (limit),
    .expire  (expire)
  );

  lw_sat_counter #(.W(RETRY_W)) u_retry (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (fail_evt),
    .count (retry_count)
  );

  assign train_en    = (state_q != ST_LOW);
  assign link_stable = (state_q == ST_STABLE);
endmodule

// File: rtl/lw_link_watchdog_chk.sv
module lw_link_watchdog_chk #(
  parameter int                  STATUS_W  = 32,
  parameter logic [STATUS_W-1:0] LINK_MASK = 'h11,
  parameter int                  LOW_CYC   = 16,
  parameter int                  RETRY_W   = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [STATUS_W-1:0] link_status,
  input logic                train_en,
  input logic                link_stable,
  input logic [RETRY_W-1:0]  retry_count,
  input logic                sample_evt,
  input logic                fail_evt
);
  logic up;
  int   low_run;

  assign up = ((link_status & LINK_MASK) == LINK_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run <= 0;
    else if (train_en) low_run <= 0;
    else               low_run <= low_run + 1;
  end

  a_r3_drop_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(train_en) |-> ($past(fail_evt) && !$past(up)));

  a_r4_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(train_en) |-> (low_run == LOW_CYC));

  a_r5_rise_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_stable) |-> ($past(sample_evt) && $past(up)));

  a_r8_loss_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (link_stable && !up) |=> (!link_stable && !train_en));

  a_r7_retry_step: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_count != $past(retry_count)) |-> ((retry_count == $past(retry_count) + 1'b1) && $fell(train_en)));

  a_r9_stable_en: assert property (@(posedge clk) disable iff (!rst_n)
    link_stable |-> train_en);
endmodule

bind lw_link_watchdog lw_link_watchdog_chk #(
  .STATUS_W  (STATUS_W),
  .LINK_MASK (LINK_MASK),
  .LOW_CYC   (LOW_CYC),
  .RETRY_W   (RETRY_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .link_status (link_status),
  .train_en    (train_en),
  .link_stable (link_stable),
  .retry_count (retry_count),
  .sample_evt  (sample_evt),
  .fail_evt    (fail_evt)
);

// File: tb/lw_link_watchdog_bench.sv
module lw_link_watchdog_bench;
  localparam int S = 20;
  localparam int R = 10;
  localparam int L = 4;
  localparam int G = 3;
  localparam int RW = 2;
  localparam int STABLE_AT = S + (G - 1) * R;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   link_status = '0;
  logic          train_en;
  logic          link_stable;
  logic [RW-1:0] retry_count;

  int n_checks = 0;
  int n_fail = 0;
  int exp_retry = 0;

  always #10 clk = ~clk;

  lw_link_watchdog #(
    .STATUS_W(32), .LINK_MASK(32'h11), .SETTLE_CYC(S), .RECHK_CYC(R),
    .LOW_CYC(L), .GOOD_NEEDED(G), .RETRY_W(RW)
  ) u_lw_link_watchdog (
    .clk(clk), .rst_n(rst_n), .link_status(link_status),
    .train_en(train_en), .link_stable(link_stable), .retry_count(retry_count)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock edge, then settle
  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic bump_retry();
    if (exp_retry < (1 << RW) - 1) exp_retry++;
  endtask

  // edges until train_en shows the wanted value
  task automatic edges_until_en(input logic want, output int n);
    n = 0;
    while (train_en !== want && n < 1000) begin
      tick();
      n++;
    end
  endtask

  task automatic t_reset();
    check(train_en === 1'b1, "R1 train_en", int'(train_en), 1);
    check(link_stable === 1'b0, "R1 link_stable", int'(link_stable), 0);
    check(retry_count === '0, "R1 retry_count", int'(retry_count), 0);
  endtask

  task automatic t_first_retry();
    int n;
    edges_until_en(1'b0, n);
    check(n == S, "R3 settle before drop", n, S);
    bump_retry();
    check(int'(retry_count) == exp_retry, "R7 count after drop", int'(retry_count), exp_retry);
    edges_until_en(1'b1, n);
    check(n == L, "R4 low pulse width", n, L);
  endtask

  task automatic t_mask_ignored();
    int n;
    int seen_stable = 0;
    link_status = ~32'h10;
    n = 0;
    while (train_en === 1'b1 && n < 1000) begin
      tick();
      n++;
      if (link_stable) seen_stable = 1;
    end
    check(n == S, "R2 partial mask still fails", n, S);
    check(seen_stable == 0, "R2 no stable on partial mask", seen_stable, 0);
    bump_retry();
    check(int'(retry_count) == exp_retry, "R7 count", int'(retry_count), exp_retry);
  endtask

  task automatic t_stable();
    int n;
    int held = 1;
    link_status = 32'h11;
    edges_until_en(1'b1, n);
    n = 0;
    while (link_stable !== 1'b1 && n < 1000) begin
      tick();
      n++;
    end
    check(n == STABLE_AT, "R5 stable delay", n, STABLE_AT);
    for (int i = 0; i < 30; i++) begin
      tick();
      if (!link_stable || !train_en) held = 0;
    end
    check(held == 1, "R5 stable held", held, 1);
    check(int'(retry_count) == exp_retry, "R7 no count on pass", int'(retry_count), exp_retry);
  endtask

  task automatic t_loss();
    link_status = 32'h01;
    tick();
    check(link_stable === 1'b0, "R8 stable cleared", int'(link_stable), 0);
    check(train_en === 1'b0, "R8 enable dropped", int'(train_en), 0);
    bump_retry();
    check(int'(retry_count) == exp_retry, "R7 count on loss", int'(retry_count), exp_retry);
  endtask

  task automatic t_recheck_fail();
    int n;
    link_status = 32'h11;
    edges_until_en(1'b1, n);
    for (int i = 0; i < S + 2; i++) tick();
    link_status = 32'h0;
    for (int i = 0; i < R - 3; i++) tick();
    check(train_en === 1'b1, "R6 enable before recheck", int'(train_en), 1);
    tick();
    check(train_en === 1'b0, "R6 drop on failed recheck", int'(train_en), 0);
    check(link_stable === 1'b0, "R6 no stable", int'(link_stable), 0);
    bump_retry();
    check(int'(retry_count) == exp_retry, "R7 saturated", int'(retry_count), exp_retry);
    link_status = 32'h11;
    edges_until_en(1'b1, n);
    n = 0;
    while (link_stable !== 1'b1 && n < 1000) begin
      tick();
      n++;
    end
    check(n == STABLE_AT, "R6 full series again", n, STABLE_AT);
  endtask

  task automatic t_saturate();
    int n;
    for (int k = 0; k < 2; k++) begin
      link_status = 32'h0;
      edges_until_en(1'b0, n);
      bump_retry();
      link_status = 32'h11;
      edges_until_en(1'b1, n);
      link_status = 32'h0;
    end
    check(int'(retry_count) == exp_retry && exp_retry == 3, "R7 holds at max",
          int'(retry_count), 3);
  endtask

  initial begin
    #2000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    t_reset();
    t_first_retry();
    t_mask_ignored();
    t_stable();
    t_loss();
    t_recheck_fail();
    t_saturate();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule